// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is a hardware master for the serial management channel that an Ethernet MAC uses to reach the registers of a PHY. A host asserts a one-cycle start pulse along with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then generates the management clock and runs one complete frame on the shared data line. When the frame is over it returns a one-cycle done pulse, an error flag and, for reads, the 16-bit register value.

The pad is presented as three signals: a data output, an output enable and a data input, so the tristate buffer sits outside the block. The management clock half-period is a parameter counted in system clocks. Every frame starts with a full preamble. On a read, the block checks that the PHY pulls the turnaround bit low. If the PHY does not, the block abandons the frame, clocks a recovery run with the line released and reports an error. Every transaction ends with a short run of extra clocks.

Top module: `mdio_master`

## Requirements
- R1: Each transaction begins with 32 management clock cycles during which the master drives the data line high.
- R2: After the preamble the master drives the start pattern 0,1 and then the opcode: 1,0 for a read and 0,1 for a write.
- R3: After the opcode it drives the 5-bit PHY address and then the 5-bit register address, each most significant bit first.
- R4: On a write, after the register address it drives the turnaround as 1 then 0, followed by the 16 data bits, most significant bit first.
- R5: On a read, the master releases the line (output enable low) for the one turnaround cycle after the register address and samples the line at the end of that cycle's high phase. A sampled 0 lets the read continue.
- R6: If the sampled read turnaround bit is 1, the master issues 32 more clock cycles with the line released. It then ends with the error flag high and read data equal to zero, for 79 clock cycles in total.
- R7: On a successful read, 16 data bits are captured most significant bit first. Each bit is sampled at the end of the high phase of its clock cycle and appears on the read data output.
- R8: A successful read ends with two extra clock cycles after the data, for 65 clock cycles in total, with the error flag low.
- R9: A write releases the line after the last data bit and adds one extra clock cycle, for 65 clock cycles in total, 64 of them driven.
- R10: The driven data value and the output enable change only while the management clock is low, so both are stable across every rising edge.
- R11: After reset and between transactions, the management clock is low, the output enable is low, and no clock edges are produced.
- R12: A start pulse that arrives while a transaction is in progress is ignored and does not alter the frame in progress.
- R13: Done is a single-cycle pulse, exactly one per transaction. Read data and the error flag change only when done is issued and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a transaction |
| rd_i | input | 1 | 1 selects a read, 0 a write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write |
| rdata_o | output | 16 | Data returned by the last read (zero after an error) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last transaction failed its turnaround check |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Value observed on the data line |

## Verification
The hardest condition to reach from the ports is the failed turnaround. It depends on what the line carries in one particular released clock cycle of a read, not on anything the host supplies. The bench contains a small PHY model that counts rising edges of the management clock and drives the line after each falling edge. It can be told to hold the turnaround bit at 1, which forces the recovery run, and a normal read afterwards then confirms that the master recovers. A start pulse is also injected in the middle of a write to show that the frame is unaffected.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_TA,
    ST_RDAT,
    ST_RECOV,
    ST_TAIL,
    ST_DONE
  } mdio_state_e;

  localparam logic [1:0] SOF_BITS   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TA_DRIVEN  = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic bit_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          last;

  assign last    = (cnt == CNT_LAST);
  assign bit_end = run && mdc && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_mdc_rests_low_R11: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb,
  output logic         nxt
);
  logic [W-1:0] sr;

  assign msb = sr[W-1];
  assign nxt = sr[W-2];

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr)  word <= '0;
    else if (sample) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int PRE_BITS   = 32,
  parameter int RECOV_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int HDR_RD   = 4 + 2 * ADDR_W;
  localparam int FRAME_WR = HDR_RD + 2 + DATA_W;
  localparam int MAXB1    = (PRE_BITS > RECOV_BITS) ? PRE_BITS : RECOV_BITS;
  localparam int MAXB     = (MAXB1 > FRAME_WR) ? MAXB1 : FRAME_WR;
  localparam int CNT_W    = $clog2(MAXB + 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_RD - 1);
  localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(FRAME_WR - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_BITS - 1);
  localparam logic [CNT_W-1:0] TAIL_RD    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TAIL_WR    = CNT_W'(0);

  mdio_state_e       state;
  logic [CNT_W-1:0]  bitcnt;
  logic              is_rd;
  logic              err_pend;
  logic              run;
  logic              bit_end;
  logic              tx_msb;
  logic              tx_nxt;
  logic              accept;
  logic [FRAME_WR-1:0] frame_val;
  logic [DATA_W-1:0] rx_word;

  assign run    = (state != ST_IDLE) && (state != ST_DONE);
  assign accept = (state == ST_IDLE) && start_i;

  always_comb begin
    if (rd_i)
      frame_val = {SOF_BITS, OP_READ, phy_addr_i, reg_addr_i,
                   {(FRAME_WR - HDR_RD){1'b0}}};
    else
      frame_val = {SOF_BITS, OP_WRITE, phy_addr_i, reg_addr_i,
                   TA_DRIVEN, wdata_i};
  end

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .mdc     (mdc_o),
    .bit_end (bit_end)
  );

  mdio_tx_shift #(.W(FRAME_WR)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (frame_val),
    .shift    (bit_end && (state == ST_HDR)),
    .msb      (tx_msb),
    .nxt      (tx_nxt)
  );

  mdio_rx_capture #(.W(DATA_W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .sample (bit_end && (state == ST_RDAT)),
    .din    (mdio_i),
    .word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      is_rd     <= 1'b0;
      err_pend  <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          state     <= ST_PRE;
          is_rd     <= rd_i;
          err_pend  <= 1'b0;
          bitcnt    <= '0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b1;
        end
        ST_PRE: if (bit_end) begin
          if (bitcnt == PRE_LAST) begin
            state  <= ST_HDR;
            bitcnt <= '0;
            mdio_o <= tx_msb;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_HDR: if (bit_end) begin
          if (bitcnt == (is_rd ? HDR_LAST : WR_LAST)) begin
            bitcnt    <= '0;
            mdio_o    <= 1'b0;
            mdio_oe_o <= 1'b0;
            state     <= is_rd ? ST_TA : ST_TAIL;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            mdio_o <= tx_nxt;
          end
        end
        ST_TA: if (bit_end) begin
          bitcnt <= '0;
          if (mdio_i) begin
            err_pend <= 1'b1;
            state    <= ST_RECOV;
          end else begin
            state <= ST_RDAT;
          end
        end
        ST_RDAT: if (bit_end) begin
          if (bitcnt == DATA_LAST) begin
            bitcnt <= '0;
            state  <= ST_TAIL;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_RECOV: if (bit_end) begin
          if (bitcnt == RECOV_LAST) begin
            bitcnt <= '0;
            state  <= ST_DONE;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_TAIL: if (bit_end) begin
          if (bitcnt == (is_rd ? TAIL_RD : TAIL_WR)) begin
            bitcnt <= '0;
            state  <= ST_DONE;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_DONE: begin
          done_o  <= 1'b1;
          err_o   <= err_pend;
          rdata_o <= err_pend ? '0 : rx_word;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: preamble cycles drive a high level
  assert_preamble_high_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE) |-> (mdio_oe_o && mdio_o));

  // R5: line released while the turnaround bit is sampled
  assert_ta_released_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TA) |-> !mdio_oe_o);

  // R6: a failed check reports zero data
  assert_err_no_data_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && err_pend) |=> (err_o && rdata_o == '0));

  // R10: pad outputs never move while the clock is high, nor on a rising edge
  assert_drive_change_low_R10: assert property (@(posedge clk) disable iff (rst)
    !($stable(mdio_o) && $stable(mdio_oe_o)) |-> !mdc_o);
  assert_drive_hold_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R11: no clocking and no driving at rest
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!mdc_o && !mdio_oe_o));

  // R12: an extra start while busy leaves the operation unchanged
  assert_busy_start_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start_i) |=> $stable(is_rd));

  // R13: single-cycle done, results only move at completion
  assert_done_single_R13: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_results_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (state != ST_DONE) |=> ($stable(rdata_o) && $stable(err_o)));

endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd = 1'b0;
  logic [4:0]  phy = '0;
  logic [4:0]  regad = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done, err, mdc, mdo, mdoe;
  logic        mdi = 1'b1;

  always #2.5 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst(rst), .start_i(start), .rd_i(rd),
    .phy_addr_i(phy), .reg_addr_i(regad), .wdata_i(wdata),
    .rdata_o(rdata), .done_o(done), .err_o(err),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY model and line monitor
  bit          rsp_en = 0;
  logic        ta_val = 1'b0;
  logic [15:0] rsp_data = '0;
  int          rise_cnt = 0;
  int          drv_n = 0;
  logic [63:0] tx_bits = '0;
  logic        oe_ta = 1'b1;
  int          done_cnt = 0;
  int          viol = 0;
  logic        prev_o = 1'b0;
  logic        prev_oe = 1'b0;

  always @(posedge mdc) begin
    rise_cnt++;
    if (mdoe) begin
      tx_bits = {tx_bits[62:0], mdo};
      drv_n++;
    end
    if (rise_cnt == 47) oe_ta = mdoe;
  end

  always @(negedge mdc) begin
    int b;
    b = rise_cnt + 1;
    if (rsp_en && b == 47) mdi = ta_val;
    else if (rsp_en && b >= 48 && b <= 63) mdi = rsp_data[63-b];
    else mdi = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && (mdo !== prev_o || mdoe !== prev_oe)) viol++;
    prev_o  = mdo;
    prev_oe = mdoe;
    if (done === 1'b1) done_cnt++;
  end

  task automatic run_txn(input bit r, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic ta, input logic [15:0] rsp,
                         input int poke);
    int n;
    rsp_en = r; ta_val = ta; rsp_data = rsp;
    rise_cnt = 0; drv_n = 0; tx_bits = '0; oe_ta = 1'b1; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; rd = r; phy = pa; regad = ra; wdata = wd;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (done !== 1'b1 && n < 20000) begin
      if (poke != 0 && n == poke) begin
        start = 1'b1; rd = ~r; phy = ~pa; regad = ~ra; wdata = ~wd;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (n >= 20000) chk(1'b0, "watchdog done R13", 0, 1);
  endtask

  task automatic check_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    chk(tx_bits[63:32] == 32'hFFFF_FFFF, "R1 write preamble", tx_bits[63:32], 32'hFFFF_FFFF);
    chk(tx_bits[31:28] == 4'b0101, "R2 write start/op", tx_bits[31:28], 4'b0101);
    chk(tx_bits[27:18] == {pa, ra}, "R3 write addresses", tx_bits[27:18], {pa, ra});
    chk(tx_bits[17:0] == {2'b10, wd}, "R4 write ta/data", tx_bits[17:0], {2'b10, wd});
    chk(rise_cnt == 65 && drv_n == 64, "R9 write length", {rise_cnt, drv_n}, {32'd65, 32'd64});
  endtask

  task automatic check_read_hdr(input logic [4:0] pa, input logic [4:0] ra);
    chk(drv_n == 46, "R5 read driven bits", drv_n, 46);
    chk(tx_bits[45:14] == 32'hFFFF_FFFF, "R1 read preamble", tx_bits[45:14], 32'hFFFF_FFFF);
    chk(tx_bits[13:10] == 4'b0110, "R2 read start/op", tx_bits[13:10], 4'b0110);
    chk(tx_bits[9:0] == {pa, ra}, "R3 read addresses", tx_bits[9:0], {pa, ra});
    chk(oe_ta == 1'b0, "R5 turnaround released", oe_ta, 0);
  endtask

  task automatic idle_check(input string tag);
    int rc;
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {"R13 one done ", tag}, done_cnt, 1);
    rc = rise_cnt;
    repeat (40) @(negedge clk);
    chk(!mdc && !mdoe && rise_cnt == rc, {"R11 idle ", tag}, {mdc, mdoe, 30'(rise_cnt)}, {2'b00, 30'(rc)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R13 actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [4:0]  ra;
    logic [15:0] wd;
    logic [15:0] hold_d;
    logic        hold_e;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mdc && !mdoe && !done && !err && rdata == 0, "R11 reset state",
        {mdc, mdoe, done, err, rdata}, 0);

    // writes: sweep every PHY address
    for (int p = 0; p < 32; p++) begin
      ra = 5'((p * 7 + 3) % 32);
      wd = 16'hC35A ^ (16'(p) * 16'h0841);
      run_txn(1'b0, 5'(p), ra, wd, 1'b0, 16'h0, 0);
      check_write(5'(p), ra, wd);
      chk(!err, "R9 write no error", err, 0);
      if (p % 8 == 0) idle_check("after write");
      else repeat (3) @(negedge clk);
    end

    // reads: sweep every PHY address with a good turnaround
    for (int p = 0; p < 32; p++) begin
      ra = 5'((p * 11 + 5) % 32);
      wd = 16'h3C96 + 16'(p) * 16'h1357;
      run_txn(1'b1, 5'(p), ra, 16'h0, 1'b0, wd, 0);
      check_read_hdr(5'(p), ra);
      chk(rdata == wd, "R7 read data", rdata, wd);
      chk(!err && rise_cnt == 65, "R8 read length/no error", {err, 31'(rise_cnt)}, {1'b0, 31'd65});
      if (p % 8 == 0) idle_check("after read");
      else repeat (3) @(negedge clk);
    end

    // read data corners
    run_txn(1'b1, 5'd1, 5'd2, 16'h0, 1'b0, 16'hFFFF, 0);
    chk(rdata == 16'hFFFF, "R7 all ones", rdata, 16'hFFFF);
    run_txn(1'b1, 5'd1, 5'd2, 16'h0, 1'b0, 16'h8001, 0);
    chk(rdata == 16'h8001, "R7 msb/lsb order", rdata, 16'h8001);
    repeat (3) @(negedge clk);

    // failed turnaround
    run_txn(1'b1, 5'd9, 5'd17, 16'h0, 1'b1, 16'hABCD, 0);
    chk(err && rdata == 0, "R6 error flag, zero data", {err, rdata}, {1'b1, 16'h0});
    chk(rise_cnt == 79 && drv_n == 46, "R6 recovery length", {rise_cnt, drv_n}, {32'd79, 32'd46});
    idle_check("after error");

    // recovery: next good read works
    run_txn(1'b1, 5'd9, 5'd17, 16'h0, 1'b0, 16'h5AA5, 0);
    chk(!err && rdata == 16'h5AA5, "R6 recovers after error", {err, rdata}, {1'b0, 16'h5AA5});
    repeat (3) @(negedge clk);

    // start while busy is ignored
    run_txn(1'b0, 5'd21, 5'd6, 16'h1234, 1'b0, 16'h0, 150);
    check_write(5'd21, 5'd6, 16'h1234);
    chk(!err, "R12 busy start ignored", err, 0);
    idle_check("after busy poke");

    // results hold until next completion
    run_txn(1'b1, 5'd3, 5'd4, 16'h0, 1'b0, 16'h7E81, 0);
    hold_d = rdata; hold_e = err;
    rd = 1'b0; phy = 5'd0; regad = 5'd0;
    repeat (200) @(negedge clk);
    chk(rdata == hold_d && err == hold_e && rdata == 16'h7E81, "R13 results held",
        {err, rdata}, {hold_e, hold_d});

    chk(viol == 0, "R10 drive changes only while clock low", viol, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule